// File: doc/BRIEF.md
# Period-Match Interval Timer

This block is an 8-bit interval timer clocked by the core clock and advanced only by a one-cycle instruction tick strobe. It cannot count external pulses. A selectable prescaler divides the tick by 1, 4 or 16 to form count events. The count climbs to a programmable period value. On the count event after the count equals that value, the count returns to zero. That event is called a match-reset.

Match-resets feed a 4-bit postscaler. The interrupt flag is raised only once every N match-resets, and N runs from 1 to 16. Software drives the block through write strobes. One strobe loads the count and one loads the period. A third loads the run bit and both divider selects together. The flag holds until software clears it.

Top module: `period_timer`

## Requirements
- R1: After reset the count and flag read 0, the run bit is off, the period is 0xFF, the prescale select is 00 and the postscale code is 0000.
- R2: The count changes on a count event only when the run bit is 1 and tick_i is high. With run off, or with tick_i low, the count holds.
- R3: Prescale select 00 gives one count event per tick. Select 01 gives one event per 4 ticks. Selects 10 and 11 each give one event per 16 ticks.
- R4: On a count event the count goes to 0 if it equals the period, and otherwise it goes up by one.
- R5: With postscale code n, the flag is set on every (n+1)-th match-reset. Code 0000 sets it on each match-reset, 0111 on every 8th and 1111 on every 16th. A match-reset that does not complete the ratio leaves the flag unchanged.
- R6: A count write loads the written value and clears the progress of both the prescaler and the postscaler. It takes priority over a count event in the same cycle.
- R7: The flag stays set until flag_clr_i is pulsed. When a set and a clear happen in the same cycle, the flag ends up set.
- R8: Period and divider writes apply from the next cycle. With period 0 the count stays at 0 and every count event is a match-reset. A count above the period runs up to 0xFF and wraps to 0 without a match-reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction tick strobe |
| cfg_we_i | input | 1 | Write strobe for run bit and divider selects |
| run_i | input | 1 | Run bit value to write |
| pre_sel_i | input | 2 | Prescale select to write |
| post_sel_i | input | 4 | Postscale code to write (ratio = code + 1) |
| per_we_i | input | 1 | Period write strobe |
| per_i | input | 8 | Period value to write |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_i | input | 8 | Count value to write |
| flag_clr_i | input | 1 | Flag clear pulse |
| cnt_o | output | 8 | Current count |
| flag_o | output | 1 | Interrupt flag |

## Verification
Directed runs use the default period of 0xFF, small periods and a period of 0. These separate match-reset from plain 8-bit rollover. Each prescale select is run with the tick held high, and ticks are sent with run off and run on with tick low. Together these expose a wrong divider, a count that moves when it should not, and lost prescaler progress.

Postscale codes 0000, 0001, 0111 and 1111 are each checked one match-reset short of the ratio and at the ratio. Count writes in the middle of a prescale or postscale interval show whether the accumulated progress is cleared. A final stretch of random ticks and writes is compared against a reference model on every clock, which catches interactions the directed cases miss.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned PRE_MAX_DIV = 16;
  localparam int unsigned PRE_CNT_W   = $clog2(PRE_MAX_DIV);

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV4   = 2'b01,
    PRE_DIV16A = 2'b10,
    PRE_DIV16B = 2'b11
  } pre_sel_e;

  // terminal value of the prescale accumulator for a select
  function automatic logic [PRE_CNT_W-1:0] pre_last(input pre_sel_e sel);
    case (sel)
      PRE_DIV1: return '0;
      PRE_DIV4: return PRE_CNT_W'(3);
      default:  return PRE_CNT_W'(PRE_MAX_DIV - 1);
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     tick_i,
  input  logic     clr_i,
  input  pre_sel_e sel_i,
  output logic     evt_o
);
  logic [PRE_CNT_W-1:0] acc_q;
  logic                 hit;

  // >= keeps a select change mid-interval from stalling the divider
  assign hit   = acc_q >= pre_last(sel_i);
  assign evt_o = en_i & tick_i & hit & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               acc_q <= '0;
    else if (clr_i)            acc_q <= '0;
    else if (en_i && tick_i)   acc_q <= hit ? '0 : acc_q + 1'b1;
  end

  // R3
  pre_div1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PRE_DIV1 && en_i && tick_i && !clr_i) |-> evt_o);

  // R6
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !(evt_o && $past(sel_i) != PRE_DIV1 && sel_i == $past(sel_i)));
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             match;

  assign match  = cnt_q == per_i;
  assign wrap_o = evt_i & ~load_i & match;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (evt_i)  cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !load_i && cnt_q == per_i) |=> cnt_q == '0);

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !load_i && cnt_q != per_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R6
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler #(
  parameter int unsigned POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic              clr_i,
  input  logic [POST_W-1:0] ratio_i,
  output logic              set_o
);
  logic [POST_W-1:0] acc_q;
  logic              hit;

  assign hit   = acc_q >= ratio_i;
  assign set_o = wrap_i & ~clr_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (wrap_i) acc_q <= hit ? '0 : acc_q + 1'b1;
  end

  // R5
  set_needs_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> wrap_i);

  // R5
  ratio_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !clr_i && ratio_i == '0) |-> set_o);
endmodule

// File: rtl/period_timer.sv
module period_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_we_i,
  input  logic              run_i,
  input  logic [1:0]        pre_sel_i,
  input  logic [POST_W-1:0] post_sel_i,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o
);
  logic              run_q;
  pre_sel_e          pre_q;
  logic [POST_W-1:0] post_q;
  logic [CNT_W-1:0]  per_q;
  logic              flag_q;
  logic              evt, wrap, set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pre_q  <= PRE_DIV1;
      post_q <= '0;
    end else if (cfg_we_i) begin
      run_q  <= run_i;
      pre_q  <= pre_sel_e'(pre_sel_i);
      post_q <= post_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       per_q <= '1;
    else if (per_we_i) per_q <= per_i;
  end

  ptmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .tick_i (tick_i),
    .clr_i  (cnt_we_i),
    .sel_i  (pre_q),
    .evt_o  (evt)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_i),
    .per_i      (per_q),
    .cnt_o      (cnt_o),
    .wrap_o     (wrap)
  );

  ptmr_postscaler #(.POST_W(POST_W)) u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .clr_i   (cnt_we_i),
    .ratio_i (post_q),
    .set_o   (set)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (set)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_we_i) |=> $stable(cnt_o));

  // R2
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_o));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set && flag_clr_i) |=> flag_o);

  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(wrap));
endmodule

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cfg_we = 1'b0, run = 1'b0;
  logic [1:0] pre_sel = '0;
  logic [3:0] post_sel = '0;
  logic       per_we = 1'b0, cnt_we = 1'b0, clr = 1'b0;
  logic [7:0] per_d = '0, cnt_d = '0;
  logic [7:0] cnt_o;
  logic       flag_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  period_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cfg_we_i(cfg_we), .run_i(run), .pre_sel_i(pre_sel), .post_sel_i(post_sel),
    .per_we_i(per_we), .per_i(per_d), .cnt_we_i(cnt_we), .cnt_i(cnt_d),
    .flag_clr_i(clr), .cnt_o(cnt_o), .flag_o(flag_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_per, m_div, m_pacc, m_ratio, m_qacc;
  bit m_run, m_flag, m_ev, m_mt, m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 255; m_div = 1; m_pacc = 0;
      m_ratio = 1; m_qacc = 0; m_run = 0; m_flag = 0;
    end else begin
      m_ev = 0; m_mt = 0; m_st = 0;
      if (cnt_we) begin
        m_cnt = cnt_d; m_pacc = 0; m_qacc = 0;
      end else if (m_run && tick) begin
        m_pacc++;
        if (m_pacc >= m_div) begin m_pacc = 0; m_ev = 1; end
      end
      if (m_ev) begin
        if (m_cnt == m_per) begin m_cnt = 0; m_mt = 1; end
        else m_cnt = (m_cnt + 1) % 256;
      end
      if (m_mt) begin
        m_qacc++;
        if (m_qacc >= m_ratio) begin m_qacc = 0; m_st = 1; end
      end
      if (m_st) m_flag = 1;
      else if (clr) m_flag = 0;
      if (cfg_we) begin
        m_run = run;
        m_div = (pre_sel == 2'b00) ? 1 : (pre_sel == 2'b01) ? 4 : 16;
        m_ratio = int'(post_sel) + 1;
      end
      if (per_we) m_per = per_d;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 model count", int'(cnt_o), m_cnt);
      chk("R7 model flag", int'(flag_o), int'(m_flag));
    end
  end

  task automatic step(input bit tk);
    tick = tk;
    @(negedge clk);
    tick = 0; cfg_we = 0; per_we = 0; cnt_we = 0; clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic cfg(input bit r, input logic [1:0] p, input logic [3:0] q);
    cfg_we = 1; run = r; pre_sel = p; post_sel = q;
    step(1'b0);
  endtask

  task automatic wr_per(input logic [7:0] v);
    per_we = 1; per_d = v; step(1'b0);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1; cnt_d = v; step(1'b0);
  endtask

  task automatic do_clr();
    clr = 1; step(1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 flag", int'(flag_o), 0);
    ticks(3);
    chk("R1 run off", int'(cnt_o), 0);

    // R1 default period 0xFF, R4 match-reset
    cfg(1, 2'b00, 4'd0);
    ticks(255);
    chk("R1 count at 255", int'(cnt_o), 255);
    chk("R4 no flag before match", int'(flag_o), 0);
    ticks(1);
    chk("R4 wrap to zero", int'(cnt_o), 0);
    chk("R5 ratio 1 flag", int'(flag_o), 1);

    // R7 sticky and clear
    step(0); step(0); step(0);
    chk("R7 sticky", int'(flag_o), 1);
    do_clr();
    chk("R7 cleared", int'(flag_o), 0);
    wr_per(8'd2); wr_cnt(8'd2);
    clr = 1; step(1);
    chk("R7 set wins", int'(flag_o), 1);
    chk("R4 period 2 wrap", int'(cnt_o), 0);
    do_clr();

    // R2 gating
    wr_cnt(8'd1);
    cfg(0, 2'b00, 4'd0);
    ticks(5);
    chk("R2 run off holds", int'(cnt_o), 1);
    cfg(1, 2'b00, 4'd0);
    step(0); step(0); step(0);
    chk("R2 no tick holds", int'(cnt_o), 1);
    step(1);
    chk("R2 tick advances", int'(cnt_o), 2);

    // R3 prescale selects
    wr_per(8'd200);
    cfg(1, 2'b01, 4'd0); wr_cnt(8'd0);
    ticks(3);
    chk("R3 div4 early", int'(cnt_o), 0);
    ticks(1);
    chk("R3 div4", int'(cnt_o), 1);
    cfg(1, 2'b10, 4'd0); wr_cnt(8'd0);
    ticks(15);
    chk("R3 div16 sel10 early", int'(cnt_o), 0);
    ticks(1);
    chk("R3 div16 sel10", int'(cnt_o), 1);
    cfg(1, 2'b11, 4'd0); wr_cnt(8'd0);
    ticks(15);
    chk("R3 div16 sel11 early", int'(cnt_o), 0);
    ticks(1);
    chk("R3 div16 sel11", int'(cnt_o), 1);

    // R6 prescaler cleared by count write
    cfg(1, 2'b01, 4'd0); wr_cnt(8'd0);
    ticks(2);
    wr_cnt(8'd5);
    ticks(3);
    chk("R6 prescale cleared", int'(cnt_o), 5);
    ticks(1);
    chk("R6 prescale restart", int'(cnt_o), 6);
    cfg(1, 2'b00, 4'd0);
    cnt_we = 1; cnt_d = 8'd9; step(1);
    chk("R6 load beats event", int'(cnt_o), 9);
    step(1);
    chk("R6 after load", int'(cnt_o), 10);

    // R6 postscaler cleared by count write
    do_clr();
    cfg(1, 2'b00, 4'd1); wr_per(8'd0); wr_cnt(8'd0);
    ticks(1);
    chk("R5 1:2 first match", int'(flag_o), 0);
    wr_cnt(8'd0);
    ticks(1);
    chk("R6 postscale cleared", int'(flag_o), 0);
    ticks(1);
    chk("R6 postscale second", int'(flag_o), 1);

    // R5 ratio 1:8
    do_clr();
    cfg(1, 2'b00, 4'd7); wr_per(8'd1); wr_cnt(8'd0);
    ticks(15);
    chk("R5 1:8 seven matches", int'(flag_o), 0);
    ticks(1);
    chk("R5 1:8 eighth match", int'(flag_o), 1);

    // R5 ratio 1:16, R8 period 0
    do_clr();
    cfg(1, 2'b00, 4'd15); wr_per(8'd0); wr_cnt(8'd0);
    ticks(15);
    chk("R8 period 0 holds zero", int'(cnt_o), 0);
    chk("R5 1:16 fifteen matches", int'(flag_o), 0);
    ticks(1);
    chk("R5 1:16 sixteenth", int'(flag_o), 1);

    // R8 period update and count above period
    do_clr();
    cfg(1, 2'b00, 4'd0); wr_per(8'd4); wr_cnt(8'd0);
    ticks(4);
    chk("R8 new period top", int'(cnt_o), 4);
    ticks(1);
    chk("R8 new period wrap", int'(cnt_o), 0);
    do_clr();
    wr_per(8'd3); wr_cnt(8'd250);
    ticks(5);
    chk("R8 above period climbs", int'(cnt_o), 255);
    ticks(1);
    chk("R8 rollover", int'(cnt_o), 0);
    chk("R8 rollover no flag", int'(flag_o), 0);
    ticks(4);
    chk("R8 match after rollover", int'(flag_o), 1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r == 0) begin
        cfg_we = 1; run = ($urandom_range(0, 7) != 0);
        pre_sel = 2'($urandom_range(0, 3)); post_sel = 4'($urandom_range(0, 15));
      end else if (r == 1) begin
        per_we = 1; per_d = 8'($urandom_range(0, 12));
      end else if (r == 2) begin
        cnt_we = 1; cnt_d = 8'($urandom_range(0, 15));
      end else if (r < 6) begin
        clr = 1;
      end
      step($urandom_range(0, 3) != 0);
    end

    finish_run();
  end
endmodule